// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block is the transmit half of a single serial channel. Bytes arrive on a valid/ready stream and wait in a 512-byte FIFO. A framer takes them one at a time and serialises each one. Each character is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The character length, stop count and parity mode are taken from configuration inputs when a character is loaded.

A programmable divider sets the bit rate. The divisor input holds the divide value minus one. A 16-step sub-bit counter then stretches each bit to sixteen divider periods. Parity can be computed as odd or even, or forced to a fixed level. The parity-sense input is active low for odd parity. A break input forces the line to the spacing level. A loopback input steers the serial stream toward the local receiver input and keeps the external line idle. A transmit enable gates the start of new characters. The FIFO fill level and a transmitter-empty flag are reported for the surrounding channel logic.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset the serial line is at mark (1), `txEmpty` is 1, `fifoCount` is 0 and `inReady` is 1.
- R2: Each character starts with one start bit at 0, then sends its data bits least significant bit first, and ends with stop bits at 1.
- R3: Every bit lasts exactly 16*(`cfgDivM1`+1) clock cycles, so a value of 0 gives sixteen cycles per bit.
- R4: `cfgLen` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8. Byte bits above the selected length are not sent.
- R5: `cfgTwoStop` at 1 sends two stop bits, and at 0 sends one.
- R6: With `cfgParEn` at 1, a parity bit follows the last data bit. `cfgEvenSel` at 0 makes the count of ones over data and parity odd, and at 1 makes it even. With `cfgParEn` at 0, no parity bit is sent.
- R7: With `cfgParEn` and `cfgStick` both at 1, the parity bit is 1 when `cfgEvenSel` is 0 and 0 when `cfgEvenSel` is 1, whatever the data.
- R8: While `txEnable` is 0, no new character starts: the line stays at mark and queued bytes stay in the FIFO.
- R9: The FIFO holds 512 bytes and `fifoCount` reports its occupancy. `inReady` is 0 when it is full, and a byte offered then is not stored.
- R10: While `cfgBreak` is 1, the transmitted stream is held at 0.
- R11: With `cfgLoop` at 1, `loopRx` carries the transmitted stream and `txLine` stays at 1. With `cfgLoop` at 0, `loopRx` follows `rxIn`.
- R12: `txEmpty` is 1 only when the FIFO is empty and the last stop bit of the last character has run its full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inData | input | 8 | Byte offered to the FIFO |
| inValid | input | 1 | `inData` is valid |
| inReady | output | 1 | FIFO can accept a byte |
| txEnable | input | 1 | Allows new characters to start |
| cfgDivM1 | input | DIV_W (16) | Bit-rate divisor minus one |
| cfgLen | input | 2 | Data length code (5 to 8 bits) |
| cfgTwoStop | input | 1 | Two stop bits when 1 |
| cfgParEn | input | 1 | Parity bit enable |
| cfgEvenSel | input | 1 | 0 selects odd parity, 1 selects even |
| cfgStick | input | 1 | Parity forced to a fixed level |
| cfgBreak | input | 1 | Hold the stream at spacing |
| cfgLoop | input | 1 | Route the stream to `loopRx`, idle `txLine` |
| rxIn | input | 1 | External receive line |
| txLine | output | 1 | Serial transmit line |
| loopRx | output | 1 | Receiver input: loopback stream or `rxIn` |
| fifoCount | output | 10 | Bytes held in the FIFO |
| txEmpty | output | 1 | FIFO empty and shifter idle |

## Verification
The hardest conditions to reach are the FIFO full boundary and the last cycle of the final stop bit. For the first, the bench holds `txEnable` low so nothing drains, then streams 512 back-to-back bytes followed by one extra byte. For the second, the bench finds the falling edge of each start bit. It then counts whole bit periods from that edge, so it can sample `txEmpty` one cycle before and one cycle after the frame ends. Loopback frames are decoded from `loopRx` in the same way while the bench watches `txLine` stay at mark.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 4;

  typedef struct packed {
    logic       load;
    logic       shift;
  } txStrobe_t;

  typedef struct packed {
    logic [1:0] len;
    logic       twoStop;
    logic       parEn;
    logic       evenSel;
    logic       stick;
  } frameCfg_t;

  // start + data(5..8) + parity + stop(1..2)
  function automatic logic [3:0] frameBits(frameCfg_t c);
    return 4'd7 + {2'b00, c.len} + {3'b000, c.parEn} + {3'b000, c.twoStop};
  endfunction
endpackage

// File: rtl/uart_tx_dp.sv
`timescale 1ns/1ps
module uart_tx_dp
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  frameCfg_t         cfg,
  input  txStrobe_t         stb,
  output logic [CW-1:0]     fifoCount,
  output logic              fifoEmpty,
  output logic              frameBit
);
  logic [DATA_W-1:0]  mem [DEPTH];
  logic [AW-1:0]      wrPtr, rdPtr;
  logic [CW-1:0]      count;
  logic               push;
  logic [DATA_W-1:0]  headByte, masked;
  logic               xr, parBit;
  logic [3:0]         parPos;
  logic [FRAME_W-1:0] frame, shiftReg;

  assign inReady   = (count != CW'(DEPTH));
  assign push      = inValid && inReady;
  assign fifoEmpty = (count == '0);
  assign fifoCount = count;
  assign headByte  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push)
        wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (stb.load)
        rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, stb.load})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Frame assembly, LSB first; unused upper positions stay 1 as stop bits
  always_comb begin
    masked = headByte & (8'hFF >> (2'd3 - cfg.len));
    xr     = ^masked;
    parBit = cfg.stick ? ~cfg.evenSel : (cfg.evenSel ? xr : ~xr);
    parPos = 4'd6 + {2'b00, cfg.len};
    frame  = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < 5 + int'(cfg.len)) frame[1 + i] = masked[i];
    end
    if (cfg.parEn) frame[parPos] = parBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          shiftReg <= '1;
    else if (stb.load)  shiftReg <= frame;
    else if (stb.shift) shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
  end

  assign frameBit = shiftReg[0];

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R9
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> (count != '0)); // R9
endmodule

// File: rtl/uart_tx_ctrl.sv
`timescale 1ns/1ps
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             fifoEmpty,
  input  frameCfg_t        cfg,
  input  logic [DIV_W-1:0] divM1,
  output txStrobe_t        stb,
  output logic             busy
);
  logic [DIV_W-1:0] divCnt;
  logic [3:0]       subCnt;
  logic [3:0]       bitsLeft;
  logic             divWrap, bitEnd;

  assign divWrap   = (divCnt >= divM1);
  assign bitEnd    = busy && divWrap && (subCnt == 4'hF);
  assign stb.load  = !busy && txEnable && !fifoEmpty;
  assign stb.shift = bitEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      divCnt   <= '0;
      subCnt   <= '0;
      bitsLeft <= '0;
    end else if (stb.load) begin
      busy     <= 1'b1;
      divCnt   <= '0;
      subCnt   <= '0;
      bitsLeft <= frameBits(cfg);
    end else if (busy) begin
      if (divWrap) begin
        divCnt <= '0;
        subCnt <= subCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (bitEnd) begin
        bitsLeft <= bitsLeft - 1'b1;
        if (bitsLeft == 4'd1) busy <= 1'b0;
      end
    end
  end

  AST_BITS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitsLeft != 4'd0)); // R2
endmodule

// File: rtl/uart_tx_framer.sv
`timescale 1ns/1ps
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DIV_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              txEnable,
  input  logic [DIV_W-1:0]  cfgDivM1,
  input  logic [1:0]        cfgLen,
  input  logic              cfgTwoStop,
  input  logic              cfgParEn,
  input  logic              cfgEvenSel,
  input  logic              cfgStick,
  input  logic              cfgBreak,
  input  logic              cfgLoop,
  input  logic              rxIn,
  output logic              txLine,
  output logic              loopRx,
  output logic [CW-1:0]     fifoCount,
  output logic              txEmpty
);
  frameCfg_t cfg;
  txStrobe_t stb;
  logic      fifoEmpty, frameBit, busy, txInt;

  assign cfg = '{len: cfgLen, twoStop: cfgTwoStop, parEn: cfgParEn,
                 evenSel: cfgEvenSel, stick: cfgStick};

  uart_tx_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inReady(inReady), .cfg(cfg), .stb(stb), .fifoCount(fifoCount),
    .fifoEmpty(fifoEmpty), .frameBit(frameBit)
  );

  uart_tx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .fifoEmpty(fifoEmpty),
    .cfg(cfg), .divM1(cfgDivM1), .stb(stb), .busy(busy)
  );

  assign txInt   = cfgBreak ? 1'b0 : frameBit;
  assign txLine  = cfgLoop ? 1'b1 : txInt;
  assign loopRx  = cfgLoop ? txInt : rxIn;
  assign txEmpty = fifoEmpty && !busy;

  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> frameBit); // R12
  AST_LOAD_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(txEnable)); // R8
  AST_START_BIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !frameBit); // R2
endmodule

// File: tb/uart_tx_framer_bench.sv
`timescale 1ns/1ps
module uart_tx_framer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        txEnable = 1'b1;
  logic [15:0] cfgDivM1 = '0;
  logic [1:0]  cfgLen = 2'd3;
  logic        cfgTwoStop = 1'b0, cfgParEn = 1'b0, cfgEvenSel = 1'b0;
  logic        cfgStick = 1'b0, cfgBreak = 1'b0, cfgLoop = 1'b0, rxIn = 1'b1;
  logic        txLine, loopRx, txEmpty;
  logic [9:0]  fifoCount;
  int          tests = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  uart_tx_framer u_uart_tx_framer (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inReady(inReady), .txEnable(txEnable), .cfgDivM1(cfgDivM1),
    .cfgLen(cfgLen), .cfgTwoStop(cfgTwoStop), .cfgParEn(cfgParEn),
    .cfgEvenSel(cfgEvenSel), .cfgStick(cfgStick), .cfgBreak(cfgBreak),
    .cfgLoop(cfgLoop), .rxIn(rxIn), .txLine(txLine), .loopRx(loopRx),
    .fifoCount(fifoCount), .txEmpty(txEmpty)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    inData = b;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Push one byte and decode the frame it produces
  task automatic runFrame(input logic [7:0] b, input logic [1:0] len,
                          input bit twoStop, input bit parEn, input bit evenSel,
                          input bit stick, input int d, input bit viaLoop,
                          input string tag);
    int nData, nBits, p, ones, waitCnt;
    bit expBits[12];
    bit par, v, lineOk;
    @(negedge clk);
    cfgLen = len; cfgTwoStop = twoStop; cfgParEn = parEn;
    cfgEvenSel = evenSel; cfgStick = stick; cfgDivM1 = 16'(d);
    cfgLoop = viaLoop;
    nData = 5 + int'(len);
    ones = 0;
    for (int i = 0; i < nData; i++) ones += int'(b[i]);
    if (stick) par = !evenSel;
    else if (evenSel) par = (ones % 2) == 1;
    else par = (ones % 2) == 0;
    nBits = 0;
    expBits[nBits++] = 1'b0;
    for (int i = 0; i < nData; i++) expBits[nBits++] = b[i];
    if (parEn) expBits[nBits++] = par;
    expBits[nBits++] = 1'b1;
    if (twoStop) expBits[nBits++] = 1'b1;
    p = 16 * (d + 1);
    lineOk = 1'b1;
    pushByte(b);
    waitCnt = 0;
    while ((viaLoop ? loopRx : txLine) == 1'b1 && waitCnt < 100) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(waitCnt < 100, {tag, " start seen"}, waitCnt, 0);
    repeat (p / 2) @(negedge clk);
    for (int k = 0; k < nBits; k++) begin
      v = viaLoop ? loopRx : txLine;
      if (viaLoop && txLine !== 1'b1) lineOk = 1'b0;
      chk(v === expBits[k], $sformatf("%s bit%0d", tag, k), int'(v), int'(expBits[k]));
      if (k != nBits - 1) repeat (p) @(negedge clk);
    end
    if (viaLoop) chk(lineOk, "R11 txLine idle during loopback", int'(lineOk), 1);
    repeat (p / 2 - 1) @(negedge clk);
    chk(txEmpty === 1'b0, {tag, " R12 empty before stop end"}, int'(txEmpty), 0);
    @(negedge clk);
    chk(txEmpty === 1'b1, {tag, " R12 empty after stop end"}, int'(txEmpty), 1);
    cfgLoop = 1'b0;
  endtask

  task automatic testReset();
    chk(txLine === 1'b1, "R1 line idle", int'(txLine), 1);
    chk(txEmpty === 1'b1, "R1 txEmpty", int'(txEmpty), 1);
    chk(fifoCount === 10'd0, "R1 fifoCount", int'(fifoCount), 0);
    chk(inReady === 1'b1, "R1 inReady", int'(inReady), 1);
  endtask

  task automatic testFormats();
    runFrame(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R2 R3 8N1");
    runFrame(8'hF3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2, 1'b0, "R4 R5 R3 5N2");
    runFrame(8'h2C, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b0, "R4 6N1");
    runFrame(8'h35, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R6 7 odd");
    runFrame(8'h35, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0, "R6 7 even");
    runFrame(8'h00, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R6 8 odd zero");
    runFrame(8'h00, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R7 stick mark");
    runFrame(8'hFF, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0, "R7 stick space");
  endtask

  task automatic testEnable();
    bit held;
    int waitCnt;
    @(negedge clk);
    txEnable = 1'b0;
    cfgLen = 2'd3; cfgParEn = 1'b0; cfgTwoStop = 1'b0; cfgDivM1 = '0;
    pushByte(8'h11);
    pushByte(8'h22);
    pushByte(8'h33);
    chk(fifoCount === 10'd3, "R9 count after 3 pushes", int'(fifoCount), 3);
    held = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (txLine !== 1'b1) held = 1'b0;
    end
    chk(held, "R8 line idle while disabled", int'(held), 1);
    chk(fifoCount === 10'd3, "R8 bytes kept while disabled", int'(fifoCount), 3);
    chk(txEmpty === 1'b0, "R12 not empty with queued bytes", int'(txEmpty), 0);
    txEnable = 1'b1;
    repeat (3) @(negedge clk);
    chk(fifoCount === 10'd2, "R9 count after first load", int'(fifoCount), 2);
    waitCnt = 0;
    while (txEmpty !== 1'b1 && waitCnt < 1000) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(waitCnt > 300 && waitCnt < 1000, "R8 queued bytes sent after enable", waitCnt, 480);
  endtask

  task automatic testFull();
    @(negedge clk);
    txEnable = 1'b0;
    inValid = 1'b1;
    for (int i = 0; i < 512; i++) begin
      inData = 8'(i);
      @(negedge clk);
    end
    inValid = 1'b0;
    chk(fifoCount === 10'd512, "R9 count full", int'(fifoCount), 512);
    chk(inReady === 1'b0, "R9 inReady low when full", int'(inReady), 0);
    pushByte(8'h5A);
    chk(fifoCount === 10'd512, "R9 push ignored when full", int'(fifoCount), 512);
    txEnable = 1'b1;
    doReset();
  endtask

  task automatic testBreak();
    @(negedge clk);
    cfgBreak = 1'b1;
    repeat (2) @(negedge clk);
    chk(txLine === 1'b0, "R10 break holds line low", int'(txLine), 0);
    cfgLoop = 1'b1;
    @(negedge clk);
    chk(loopRx === 1'b0, "R10 break seen on loopback", int'(loopRx), 0);
    cfgLoop = 1'b0;
    cfgBreak = 1'b0;
    @(negedge clk);
    chk(txLine === 1'b1, "R10 line returns to mark", int'(txLine), 1);
  endtask

  task automatic testLoop();
    runFrame(8'h96, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b1, "R11 loopback frame");
    @(negedge clk);
    rxIn = 1'b0;
    @(negedge clk);
    chk(loopRx === 1'b0, "R11 loopRx follows rxIn low", int'(loopRx), 0);
    rxIn = 1'b1;
    @(negedge clk);
    chk(loopRx === 1'b1, "R11 loopRx follows rxIn high", int'(loopRx), 1);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    doReset();
    testReset();
    testFormats();
    testEnable();
    testFull();
    testReset();
    testBreak();
    testLoop();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule